// File: doc/BRIEF.md
# UART FIFO Transfer-Request Pin Generator

This block drives the two active-low request pins that a UART offers to a host or a DMA engine. The receive request pin tells the host that receive data is waiting. The transmit request pin reports whether the transmit FIFO can take more data. The block does not contain the FIFOs. It watches the receive and transmit occupancy counts and a receive time-out pulse, and it uses the two programmed trigger selections to decide the pin levels.

A mode input picks between two behaviours. In single-transfer mode each pin decodes the occupancy of its FIFO directly. In block-transfer mode each pin is a held state with hysteresis. The receive pin asserts at the trigger level or on a time-out, and releases only when its FIFO drains to empty. The transmit pin goes high when its FIFO is full, and goes low once occupancy falls below its trigger level.

Both pins are registered, so every change shows on the clock edge after the inputs that caused it. A mode change also takes effect on the next clock. On the first clock in block-transfer mode, the held state is rebuilt from the current occupancy instead of from the previous pin value.

Top module: `uart_xfer_ready`

## Requirements
- R1: After reset, and on the clock after `fifo_clr` is sampled high (in either mode), `rx_ready_n` is 1 and `tx_ready_n` is 0.
- R2: With `dma_mode` low, `rx_ready_n` on the next clock is 1 when `rx_count` is 0, and 0 otherwise.
- R3: With `dma_mode` low, `tx_ready_n` on the next clock is 1 when `tx_count` is non-zero, and 0 when it is 0.
- R4: `rx_trig_sel` values 0, 1, 2 and 3 select receive levels of 1, 4, 8 and 28 bytes. In block-transfer mode, `rx_ready_n` goes to 0 on the next clock when `rx_count` is at or above the selected level and not zero.
- R5: In block-transfer mode, an `rx_timeout` pulse with `rx_count` non-zero drives `rx_ready_n` to 0 on the next clock, even below the level. When `rx_count` is 0, the pulse leaves the pin at 1.
- R6: In block-transfer mode, `rx_ready_n` returns to 1 only on the clock after `rx_count` is 0. While the count is between 1 and the level minus one and no time-out is present, the pin keeps its previous value.
- R7: `tx_trig_sel` values 0, 1, 2 and 3 select transmit levels of 4, 8, 16 and 24 bytes. In block-transfer mode, `tx_ready_n` goes to 1 on the clock after `tx_count` reaches 32.
- R8: In block-transfer mode, `tx_ready_n` goes to 0 on the clock after `tx_count` is below the selected transmit level. From the level up to 31 entries, the pin keeps its previous value.
- R9: On the first clock with `dma_mode` high after it was low, the held states are rebuilt from the current inputs, starting from the R1 values. Dropping `dma_mode` applies the R2 and R3 rules on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous FIFO reset; forces the initial pin states |
| dma_mode | input | 1 | 1 selects block-transfer mode, 0 single-transfer mode |
| rx_count | input | 6 | Receive FIFO occupancy, 0 to 32 |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| rx_trig_sel | input | 2 | Receive trigger level selection |
| tx_count | input | 6 | Transmit FIFO occupancy, 0 to 32 |
| tx_trig_sel | input | 2 | Transmit trigger level selection |
| rx_ready_n | output | 1 | Active-low receive request pin |
| tx_ready_n | output | 1 | Active-low transmit request pin |

## Verification
Every cycle, the assertions check these rules: the single-transfer decode, the assert and release events of both pins, the hold of each pin inside its hysteresis band, the rebuild on entry to block-transfer mode, and the forced state after a FIFO clear. Some behaviour only the bench scenarios can show. These are the mapping of each trigger selection code to its byte level, and the order of transitions as a FIFO fills past a level and later drains. The bench also covers the interplay of a time-out with an empty FIFO, and the pin values across a mode exit and re-entry.

// File: rtl/uart_req_pkg.sv
package uart_req_pkg;

   localparam int unsigned DEF_DEPTH = 32;

   localparam int unsigned DEF_RX_L0 = 1;
   localparam int unsigned DEF_RX_L1 = 4;
   localparam int unsigned DEF_RX_L2 = 8;
   localparam int unsigned DEF_RX_L3 = 28;

   localparam int unsigned DEF_TX_L0 = 4;
   localparam int unsigned DEF_TX_L1 = 8;
   localparam int unsigned DEF_TX_L2 = 16;
   localparam int unsigned DEF_TX_L3 = 24;

   localparam int unsigned NUM_LEVELS = 4;

   // Initial (reset / FIFO clear) pin levels
   localparam logic RX_PIN_INIT = 1'b1;
   localparam logic TX_PIN_INIT = 1'b0;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/uart_trig_level_sel.sv
module uart_trig_level_sel
   import uart_req_pkg::*;
#(
   parameter int unsigned DEPTH = DEF_DEPTH,
   parameter int unsigned CW    = cnt_width(DEPTH),
   parameter int unsigned L0    = 1,
   parameter int unsigned L1    = 4,
   parameter int unsigned L2    = 8,
   parameter int unsigned L3    = 28,
   localparam int unsigned SW   = $clog2(NUM_LEVELS)
) (
   input  logic [SW-1:0] sel,
   output logic [CW-1:0] level
);

   localparam int unsigned LVLS [NUM_LEVELS] = '{L0, L1, L2, L3};

   logic [CW-1:0] tab [NUM_LEVELS];

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_tab
      if (LVLS[i] < 1 || LVLS[i] >= DEPTH) begin : g_bad
         $error("trigger level %0d out of range 1..DEPTH-1", i);
      end
      assign tab[i] = CW'(LVLS[i]);
   end

   assign level = tab[sel];

endmodule

// File: rtl/uart_rx_req_ctrl.sv
module uart_rx_req_ctrl
   import uart_req_pkg::*;
#(
   parameter int unsigned CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          dma_mode,
   input  logic          dma_entry,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] level,
   input  logic          timeout,
   output logic          req_n
);

   logic q;
   logic empty;
   logic hit;
   logic held;
   logic nxt;

   always_comb begin
      empty = (count == '0);
      hit   = (count >= level) || timeout;
      held  = dma_entry ? RX_PIN_INIT : q;
      if (dma_mode) begin
         if (empty)    nxt = 1'b1;
         else if (hit) nxt = 1'b0;
         else          nxt = held;
      end else begin
         nxt = empty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RX_PIN_INIT;
      else if (clr) q <= RX_PIN_INIT;
      else          q <= nxt;
   end

   assign req_n = q;

endmodule

// File: rtl/uart_tx_req_ctrl.sv
module uart_tx_req_ctrl
   import uart_req_pkg::*;
#(
   parameter int unsigned DEPTH = DEF_DEPTH,
   parameter int unsigned CW    = cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          dma_mode,
   input  logic          dma_entry,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] level,
   output logic          req_n
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic q;
   logic full;
   logic below;
   logic held;
   logic nxt;

   always_comb begin
      full  = (count == FULL);
      below = (count < level);
      held  = dma_entry ? TX_PIN_INIT : q;
      if (dma_mode) begin
         if (full)       nxt = 1'b1;
         else if (below) nxt = 1'b0;
         else            nxt = held;
      end else begin
         nxt = (count != '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= TX_PIN_INIT;
      else if (clr) q <= TX_PIN_INIT;
      else          q <= nxt;
   end

   assign req_n = q;

endmodule

// File: rtl/uart_xfer_ready.sv
module uart_xfer_ready
   import uart_req_pkg::*;
#(
   parameter int unsigned DEPTH = DEF_DEPTH,
   parameter int unsigned RX_L0 = DEF_RX_L0,
   parameter int unsigned RX_L1 = DEF_RX_L1,
   parameter int unsigned RX_L2 = DEF_RX_L2,
   parameter int unsigned RX_L3 = DEF_RX_L3,
   parameter int unsigned TX_L0 = DEF_TX_L0,
   parameter int unsigned TX_L1 = DEF_TX_L1,
   parameter int unsigned TX_L2 = DEF_TX_L2,
   parameter int unsigned TX_L3 = DEF_TX_L3,
   localparam int unsigned CW   = cnt_width(DEPTH),
   localparam int unsigned SW   = $clog2(NUM_LEVELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_clr,
   input  logic          dma_mode,
   input  logic [CW-1:0] rx_count,
   input  logic          rx_timeout,
   input  logic [SW-1:0] rx_trig_sel,
   input  logic [CW-1:0] tx_count,
   input  logic [SW-1:0] tx_trig_sel,
   output logic          rx_ready_n,
   output logic          tx_ready_n
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic          mode_q;
   logic          dma_entry;
   logic [CW-1:0] rx_level;
   logic [CW-1:0] tx_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= dma_mode;
   end

   assign dma_entry = dma_mode & ~mode_q;

   uart_trig_level_sel #(
      .DEPTH(DEPTH), .CW(CW),
      .L0(RX_L0), .L1(RX_L1), .L2(RX_L2), .L3(RX_L3)
   ) u_rx_lvl (
      .sel   (rx_trig_sel),
      .level (rx_level)
   );

   uart_trig_level_sel #(
      .DEPTH(DEPTH), .CW(CW),
      .L0(TX_L0), .L1(TX_L1), .L2(TX_L2), .L3(TX_L3)
   ) u_tx_lvl (
      .sel   (tx_trig_sel),
      .level (tx_level)
   );

   uart_rx_req_ctrl #(.CW(CW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .dma_mode  (dma_mode),
      .dma_entry (dma_entry),
      .count     (rx_count),
      .level     (rx_level),
      .timeout   (rx_timeout),
      .req_n     (rx_ready_n)
   );

   uart_tx_req_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .dma_mode  (dma_mode),
      .dma_entry (dma_entry),
      .count     (tx_count),
      .level     (tx_level),
      .req_n     (tx_ready_n)
   );

endmodule

// File: rtl/uart_xfer_ready_chk.sv
module uart_xfer_ready_chk #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_clr,
   input logic          dma_mode,
   input logic          mode_q,
   input logic [CW-1:0] rx_count,
   input logic          rx_timeout,
   input logic [CW-1:0] rx_level,
   input logic [CW-1:0] tx_count,
   input logic [CW-1:0] tx_level,
   input logic          rx_ready_n,
   input logic          tx_ready_n
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   // R1
   a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      $past(fifo_clr) |-> (rx_ready_n && !tx_ready_n));

   // R2
   a_r2_rx_decode: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && !$past(dma_mode)) |-> (rx_ready_n == ($past(rx_count) == '0)));

   // R3
   a_r3_tx_decode: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && !$past(dma_mode)) |-> (tx_ready_n == ($past(tx_count) != '0)));

   // R4
   a_r4_rx_trigger: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(rx_count) != '0
       && $past(rx_count) >= $past(rx_level)) |-> !rx_ready_n);

   // R5
   a_r5_rx_timeout: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(rx_timeout)
       && $past(rx_count) != '0) |-> !rx_ready_n);

   // R6
   a_r6_rx_release: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(rx_count) == '0) |-> rx_ready_n);

   a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(mode_q) && $past(rx_count) != '0
       && $past(rx_count) < $past(rx_level) && !$past(rx_timeout))
      |-> (rx_ready_n == $past(rx_ready_n)));

   // R7
   a_r7_tx_full: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(tx_count) == FULL) |-> tx_ready_n);

   // R8
   a_r8_tx_below: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(tx_count) < $past(tx_level)) |-> !tx_ready_n);

   a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && $past(mode_q) && $past(tx_count) != FULL
       && $past(tx_count) >= $past(tx_level)) |-> (tx_ready_n == $past(tx_ready_n)));

   // R9
   a_r9_entry_rx: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && !$past(mode_q) && $past(rx_count) != '0
       && $past(rx_count) < $past(rx_level) && !$past(rx_timeout)) |-> rx_ready_n);

   a_r9_entry_tx: assert property (@(posedge clk) disable iff (!rst_n || !pv)
      (!$past(fifo_clr) && $past(dma_mode) && !$past(mode_q) && $past(tx_count) != FULL
       && $past(tx_count) >= $past(tx_level)) |-> !tx_ready_n);

endmodule

bind uart_xfer_ready uart_xfer_ready_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_clr   (fifo_clr),
   .dma_mode   (dma_mode),
   .mode_q     (mode_q),
   .rx_count   (rx_count),
   .rx_timeout (rx_timeout),
   .rx_level   (rx_level),
   .tx_count   (tx_count),
   .tx_level   (tx_level),
   .rx_ready_n (rx_ready_n),
   .tx_ready_n (tx_ready_n)
);

// File: tb/tb_uart_xfer_ready.sv
`timescale 1ns/1ps
module tb_uart_xfer_ready;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_clr = 1'b0;
   logic       dma_mode = 1'b0;
   logic [5:0] rx_count = '0;
   logic       rx_timeout = 1'b0;
   logic [1:0] rx_trig_sel = '0;
   logic [5:0] tx_count = '0;
   logic [1:0] tx_trig_sel = '0;
   logic       rx_ready_n;
   logic       tx_ready_n;

   always #4 clk = ~clk;

   uart_xfer_ready dut (
      .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .dma_mode(dma_mode),
      .rx_count(rx_count), .rx_timeout(rx_timeout), .rx_trig_sel(rx_trig_sel),
      .tx_count(tx_count), .tx_trig_sel(tx_trig_sel),
      .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n)
   );

   typedef struct {
      bit    rx;
      bit    tx;
      string tag;
   } exp_t;

   exp_t exp_q [$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   m_rx = 1'b1;
   bit   m_tx = 1'b0;
   bit   m_mode = 1'b0;

   const int RXL [4] = '{1, 4, 8, 28};
   const int TXL [4] = '{4, 8, 16, 24};

   task automatic drive(input bit clr, input bit dma, input int rxc, input bit to,
                        input int rs, input int txc, input int ts, input string tag);
      exp_t e;
      bit   entry;
      @(negedge clk);
      fifo_clr = clr; dma_mode = dma; rx_count = 6'(rxc); rx_timeout = to;
      rx_trig_sel = 2'(rs); tx_count = 6'(txc); tx_trig_sel = 2'(ts);
      entry = dma && !m_mode;
      if (clr) begin
         m_rx = 1'b1; m_tx = 1'b0;
      end else if (!dma) begin
         m_rx = (rxc == 0); m_tx = (txc != 0);
      end else begin
         if (entry) begin m_rx = 1'b1; m_tx = 1'b0; end
         if (rxc == 0) m_rx = 1'b1;
         else if (rxc >= RXL[rs] || to) m_rx = 1'b0;
         if (txc == 32) m_tx = 1'b1;
         else if (txc < TXL[ts]) m_tx = 1'b0;
      end
      m_mode = dma;
      e.rx = m_rx; e.tx = m_tx; e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (rx_ready_n !== e.rx || tx_ready_n !== e.tx) begin
               n_fail++;
               $display("FAIL %s: rx_ready_n=%b tx_ready_n=%b expected rx=%b tx=%b",
                        e.tag, rx_ready_n, tx_ready_n, e.rx, e.tx);
            end
         end
      end
   end

   initial begin : watchdog
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state seen directly
      n_chk++;
      if (rx_ready_n !== 1'b1 || tx_ready_n !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: rx=%b tx=%b expected rx=1 tx=0", rx_ready_n, tx_ready_n);
      end
      rst_n = 1'b1;
      drive(0,0, 0,0,0,  0,0, "R1 idle after reset");
      // R2 / R3 single-transfer decode
      drive(0,0, 5,0,0,  0,0, "R2 rx nonempty");
      drive(0,0, 0,0,0,  3,0, "R3 tx nonempty");
      drive(0,0,32,0,3, 32,3, "R2 R3 both full");
      drive(0,0, 1,1,0,  1,0, "R2 timeout ignored in single mode");
      drive(0,0, 0,0,0,  0,0, "R3 tx empty");
      // R9 entry with counts inside the bands
      drive(0,1, 3,0,2, 20,1, "R9 entry mid band");
      // R4 / R6 receive with level 8
      drive(0,1, 7,0,2, 20,1, "R4 below level");
      drive(0,1, 8,0,2, 20,1, "R4 at level");
      drive(0,1, 5,0,2, 20,1, "R6 hold low");
      drive(0,1, 1,0,2, 20,1, "R6 hold low at one");
      drive(0,1, 0,0,2, 20,1, "R6 release at empty");
      drive(0,1, 2,0,2, 20,1, "R6 hold high");
      // R5 time-out
      drive(0,1, 2,1,2, 20,1, "R5 timeout asserts");
      drive(0,1, 2,0,2, 20,1, "R6 held after timeout");
      drive(0,1, 0,0,2, 20,1, "R6 release");
      drive(0,1, 0,1,2, 20,1, "R5 timeout with empty fifo");
      // R4 other selections
      drive(0,1,27,0,3, 20,1, "R4 sel3 below 28");
      drive(0,1,28,0,3, 20,1, "R4 sel3 at 28");
      drive(0,1, 0,0,3, 20,1, "R6 release");
      drive(0,1, 1,0,0, 20,1, "R4 sel0 level 1");
      drive(0,1, 0,0,1, 20,1, "R6 release");
      drive(0,1, 3,0,1, 20,1, "R4 sel1 below 4");
      drive(0,1, 4,0,1, 20,1, "R4 sel1 at 4");
      // R7 / R8 transmit
      drive(0,1, 0,0,1, 31,1, "R8 hold low below full");
      drive(0,1, 0,0,1, 32,1, "R7 full sel1");
      drive(0,1, 0,0,1, 20,1, "R8 hold high");
      drive(0,1, 0,0,1,  8,1, "R8 hold at level 8");
      drive(0,1, 0,0,1,  7,1, "R8 below level 8");
      drive(0,1, 0,0,3, 32,3, "R7 full sel3");
      drive(0,1, 0,0,3, 23,3, "R8 below level 24");
      drive(0,1, 0,0,0, 32,0, "R7 full sel0");
      drive(0,1, 0,0,0,  4,0, "R8 hold at level 4");
      drive(0,1, 0,0,0,  3,0, "R8 below level 4");
      drive(0,1, 0,0,2, 32,2, "R7 full sel2");
      drive(0,1, 0,0,2, 16,2, "R8 hold at level 16");
      drive(0,1, 0,0,2, 15,2, "R8 below level 16");
      // R1 clear in block mode
      drive(0,1,10,0,0, 32,0, "R4 setup for clear");
      drive(1,1,10,0,0, 32,0, "R1 fifo clear");
      drive(0,1,10,0,0, 32,0, "R4 after clear");
      // R9 exit and re-entry
      drive(0,0, 5,0,0,  0,0, "R9 exit to single");
      drive(0,1, 0,0,0, 32,0, "R9 re-entry empty rx full tx");
      drive(0,0, 0,0,0,  0,0, "R9 exit again");
      drive(0,1, 5,0,1, 10,1, "R9 re-entry above rx level");
      drive(1,0, 5,0,1, 10,1, "R1 clear in single mode");
      drive(0,0, 5,0,1, 10,1, "R2 R3 after clear");
      repeat (3) @(posedge clk);
      #2;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule